// File: doc/BRIEF.md
# Codec Register Access Sequencer

This block performs single register reads and writes on an audio codec attached to a serial audio link that is already running. A host presents one request made of a direction flag, a 7-bit register index and a 16-bit write value. The sequencer then steps through the access on its own. It drives the command-address and command-data words of the link controller and strobes them in. It watches the controller's transmit-side "sent" flags and receive-side "ready" flags, and clears them with write-one-to-clear masks. It applies every wait limit in microseconds and retries reads whose reply does not carry the requested index.

A prescaler divides the system clock down to a microsecond tick. Each wait state restarts that prescaler together with a saturating microsecond counter, so a limit of N µs lasts exactly N × `CLK_PER_US` cycles. Writes are attempted once. Reads get up to `READ_TRIES` attempts, and a read that fails every attempt reports 0xFFFF with the error flag set.

States and transitions:
- `S_IDLE` goes to `S_WR_CLR` or `S_RD_CLR` when a request is accepted.
- Write path: `S_WR_CLR`, then `S_WR_DATA`, then `S_WR_ADDR`, then `S_WR_WAIT`. `S_WR_WAIT` leaves on a sent flag or on timeout to `S_WR_END`, which goes to `S_FINISH`.
- Read path: `S_RD_CLR`, then `S_RD_ISSUE`, then `S_RD_ASENT`. `S_RD_ASENT` leaves on the address-sent flag or on timeout to `S_RD_ACLR`, then `S_RD_AWAIT`. `S_RD_AWAIT` leaves on address-ready or on timeout to `S_RD_DWAIT`.
- `S_RD_DWAIT` goes to `S_RD_CAPT` on data-ready, or when only one of the two ready waits timed out. When both timed out, it goes to `S_RD_CLR`, or to `S_FINISH` once the attempts are used up.
- `S_RD_CAPT` goes to `S_FINISH` on an index match or once the attempts are used up. Otherwise it goes to `S_RD_GAP`, which returns to `S_RD_CLR` when the gap time has passed.
- `S_FINISH` returns to `S_IDLE`.

Top module: `codec_reg_engine`

## Requirements
- R1: After reset, busy, done and err are 0, rd_data is 0, and no command strobe is raised while busy is low.
- R2: cmd_addr_word holds the register index in bits 18:12 and the direction in bit 19 (1 = read, 0 = write), with every other bit 0. cmd_data_word holds the 16-bit write value in bits 19:4, with every other bit 0.
- R3: A write first clears both sent flags (tx_clr bits 31 and 30 together). It then raises cmd_data_we for one cycle, and raises cmd_addr_we in the very next cycle. The two strobes are never high together.
- R4: After its address strobe, a write waits for tx_status bit 31 or bit 30 for at most WR_TMO_US µs, then clears both flags and finishes. err is 0 when a flag arrived and 1 on timeout, and the write is never reissued.
- R5: Each read attempt clears tx bit 31 and then strobes the address word with bit 19 set. It waits at most ASENT_TMO_US µs for tx bit 31 and then clears that bit. The read continues even if the flag never came.
- R6: A read attempt then waits at most READY_TMO_US µs for rx_status bit 22 (address ready), and after that at most READY_TMO_US µs more for bit 21 (data ready). If only one of the two waits times out, the reply is still captured.
- R7: If both ready waits time out, the attempt fails and the next attempt's address strobe follows with no extra gap.
- R8: On capture, rx_clr clears bits 22 and 21. If rsp_addr_word bits 18:12 equal the requested index, rd_data becomes rsp_data_word bits 19:4 and err is 0.
- R9: When the captured index differs from the request, at least RETRY_GAP_US µs pass before the next attempt's address strobe.
- R10: A read makes at most READ_TRIES attempts. When all of them fail, done comes with rd_data = 0xFFFF and err = 1.
- R11: busy rises in the cycle after a request is accepted. done is high for exactly one cycle, with busy still high, and busy falls in the next cycle.
- R12: While busy is high, req_valid is ignored: the latched command does not change and no extra access or done follows.
- R13: Every wait limit is counted in microsecond ticks of CLK_PER_US clock cycles, so the write timeout takes at least WR_TMO_US × CLK_PER_US cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, accepted only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_index | input | 7 | Codec register index |
| req_wdata | input | 16 | Write value |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read result, 0xFFFF on read failure |
| err | output | 1 | Access failed (read exhausted or write timeout) |
| cmd_addr_word | output | 32 | Command-address word to the link controller |
| cmd_addr_we | output | 1 | Load strobe for the command-address word |
| cmd_data_word | output | 32 | Command-data word to the link controller |
| cmd_data_we | output | 1 | Load strobe for the command-data word |
| tx_status | input | 2 [31:30] | Address-sent (31) and data-sent (30) flags |
| tx_clr | output | 2 [31:30] | Write-one-to-clear mask for tx_status |
| rx_status | input | 2 [22:21] | Address-ready (22) and data-ready (21) flags |
| rx_clr | output | 2 [22:21] | Write-one-to-clear mask for rx_status |
| rsp_addr_word | input | 7 [18:12] | Register index returned by the codec |
| rsp_data_word | input | 16 [19:4] | Register value returned by the codec |

## Verification
A responder model in the bench plays the controller side. It is set up per scenario to acknowledge or stay silent, to raise only some of the ready flags, and to return a wrong index for the first few attempts. The clean write and clean read check the word layouts and the order of the clear, data and address steps. The silent write separates a timed-out write from a retried one. Replies with a wrong index for two attempts, and then for every attempt, separate the retry gap and the exhaustion value. A codec that never answers separates the immediate link-down retry from the gapped retry. Replies with only the data flag, or with no address-sent acknowledge, show that one missing flag does not abort the read.

// File: rtl/codec_acc_pkg.sv
package codec_acc_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_WR_CLR,
        S_WR_DATA,
        S_WR_ADDR,
        S_WR_WAIT,
        S_WR_END,
        S_RD_CLR,
        S_RD_ISSUE,
        S_RD_ASENT,
        S_RD_ACLR,
        S_RD_AWAIT,
        S_RD_DWAIT,
        S_RD_CAPT,
        S_RD_GAP,
        S_FINISH
    } eng_state_e;

    localparam logic [15:0] RD_FAIL_VALUE = 16'hFFFF;

endpackage

// File: rtl/us_tick_gen.sv
module us_tick_gen #(
    parameter int CLK_PER_US = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int PW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam logic [PW-1:0] LAST = PW'(CLK_PER_US - 1);

    logic [PW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (restart)        cnt_q <= '0;
        else if (cnt_q == LAST)  cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
    end

    assign tick = (cnt_q == LAST);
endmodule

// File: rtl/us_window.sv
module us_window #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         expired
);
    logic [W-1:0] us_q;

    assign expired = (us_q >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 us_q <= '0;
        else if (restart)           us_q <= '0;
        else if (tick && !expired)  us_q <= us_q + 1'b1;
    end
endmodule

// File: rtl/codec_reg_engine.sv
module codec_reg_engine
    import codec_acc_pkg::*;
#(
    parameter int CLK_PER_US   = 100,
    parameter int WR_TMO_US    = 500,
    parameter int ASENT_TMO_US = 21,
    parameter int READY_TMO_US = 500,
    parameter int RETRY_GAP_US = 21,
    parameter int READ_TRIES   = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req_valid,
    input  logic         req_write,
    input  logic [6:0]   req_index,
    input  logic [15:0]  req_wdata,
    output logic         busy,
    output logic         done,
    output logic [15:0]  rd_data,
    output logic         err,
    output logic [31:0]  cmd_addr_word,
    output logic         cmd_addr_we,
    output logic [31:0]  cmd_data_word,
    output logic         cmd_data_we,
    input  logic [31:30] tx_status,
    output logic [31:30] tx_clr,
    input  logic [22:21] rx_status,
    output logic [22:21] rx_clr,
    input  logic [18:12] rsp_addr_word,
    input  logic [19:4]  rsp_data_word
);
    localparam int MAX_A  = (WR_TMO_US > READY_TMO_US) ? WR_TMO_US : READY_TMO_US;
    localparam int MAX_B  = (ASENT_TMO_US > RETRY_GAP_US) ? ASENT_TMO_US : RETRY_GAP_US;
    localparam int MAX_US = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int US_W   = $clog2(MAX_US + 1);
    localparam int TRY_W  = $clog2(READ_TRIES + 1);
    localparam logic [TRY_W-1:0] LAST_TRY = TRY_W'(READ_TRIES);

    eng_state_e       state_q, state_d;
    logic             rd_q;
    logic [6:0]       idx_q;
    logic [15:0]      wdata_q;
    logic [TRY_W-1:0] tries_q;
    logic             a_to_q;
    logic [15:0]      rd_data_q;
    logic             err_q;
    logic             rd_fail;

    logic             tmr_restart, us_tick, tmr_exp;
    logic [US_W-1:0]  tmr_limit;
    logic             idx_match, sent_any;

    assign idx_match   = (rsp_addr_word == idx_q);
    assign sent_any    = tx_status[31] | tx_status[30];
    assign tmr_restart = (state_d != state_q);

    // Wait limit chosen by the state being timed
    always_comb begin
        unique case (state_q)
            S_WR_WAIT:              tmr_limit = US_W'(WR_TMO_US);
            S_RD_ASENT:             tmr_limit = US_W'(ASENT_TMO_US);
            S_RD_AWAIT, S_RD_DWAIT: tmr_limit = US_W'(READY_TMO_US);
            S_RD_GAP:               tmr_limit = US_W'(RETRY_GAP_US);
            default:                tmr_limit = '0;
        endcase
    end

    us_tick_gen #(.CLK_PER_US(CLK_PER_US)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (tmr_restart),
        .tick    (us_tick)
    );

    us_window #(.W(US_W)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (tmr_restart),
        .tick    (us_tick),
        .limit   (tmr_limit),
        .expired (tmr_exp)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        rd_fail = 1'b0;
        unique case (state_q)
            S_IDLE:     if (req_valid) state_d = req_write ? S_WR_CLR : S_RD_CLR;
            S_WR_CLR:   state_d = S_WR_DATA;
            S_WR_DATA:  state_d = S_WR_ADDR;
            S_WR_ADDR:  state_d = S_WR_WAIT;
            S_WR_WAIT:  if (sent_any || tmr_exp) state_d = S_WR_END;
            S_WR_END:   state_d = S_FINISH;
            S_RD_CLR:   state_d = S_RD_ISSUE;
            S_RD_ISSUE: state_d = S_RD_ASENT;
            S_RD_ASENT: if (tx_status[31] || tmr_exp) state_d = S_RD_ACLR;
            S_RD_ACLR:  state_d = S_RD_AWAIT;
            S_RD_AWAIT: if (rx_status[22] || tmr_exp) state_d = S_RD_DWAIT;
            S_RD_DWAIT: begin
                if (rx_status[21]) begin
                    state_d = S_RD_CAPT;
                end else if (tmr_exp) begin
                    if (!a_to_q) begin
                        state_d = S_RD_CAPT;
                    end else if (tries_q == LAST_TRY) begin
                        state_d = S_FINISH;
                        rd_fail = 1'b1;
                    end else begin
                        state_d = S_RD_CLR;
                    end
                end
            end
            S_RD_CAPT: begin
                if (idx_match) begin
                    state_d = S_FINISH;
                end else if (tries_q == LAST_TRY) begin
                    state_d = S_FINISH;
                    rd_fail = 1'b1;
                end else begin
                    state_d = S_RD_GAP;
                end
            end
            S_RD_GAP:   if (tmr_exp) state_d = S_RD_CLR;
            S_FINISH:   state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Request, attempt and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q      <= 1'b0;
            idx_q     <= '0;
            wdata_q   <= '0;
            tries_q   <= '0;
            a_to_q    <= 1'b0;
            rd_data_q <= '0;
            err_q     <= 1'b0;
        end else begin
            if (state_q == S_IDLE && req_valid) begin
                rd_q    <= !req_write;
                idx_q   <= req_index;
                wdata_q <= req_wdata;
                tries_q <= '0;
                err_q   <= 1'b0;
            end
            if (state_q == S_RD_ISSUE) tries_q <= tries_q + 1'b1;
            if (state_q == S_RD_AWAIT && state_d == S_RD_DWAIT) a_to_q <= !rx_status[22];
            if (state_q == S_WR_WAIT && state_d == S_WR_END && !sent_any) err_q <= 1'b1;
            if (state_q == S_RD_CAPT && idx_match) begin
                rd_data_q <= rsp_data_word;
                err_q     <= 1'b0;
            end
            if (rd_fail) begin
                rd_data_q <= RD_FAIL_VALUE;
                err_q     <= 1'b1;
            end
        end
    end

    // Outputs decoded from the state
    always_comb begin
        busy        = (state_q != S_IDLE);
        done        = 1'b0;
        cmd_addr_we = 1'b0;
        cmd_data_we = 1'b0;
        tx_clr      = 2'b00;
        rx_clr      = 2'b00;
        unique case (state_q)
            S_WR_CLR, S_WR_END:  tx_clr = 2'b11;
            S_WR_DATA:           cmd_data_we = 1'b1;
            S_WR_ADDR:           cmd_addr_we = 1'b1;
            S_RD_CLR, S_RD_ACLR: tx_clr = 2'b10;
            S_RD_ISSUE:          cmd_addr_we = 1'b1;
            S_RD_CAPT:           rx_clr = 2'b11;
            S_FINISH:            done = 1'b1;
            default:             ;
        endcase
    end

    assign cmd_addr_word = {12'h000, rd_q, idx_q, 12'h000};
    assign cmd_data_word = {12'h000, wdata_q, 4'h0};
    assign rd_data       = rd_data_q;
    assign err           = err_q;
endmodule

// File: rtl/codec_reg_engine_chk.sv
module codec_reg_engine_chk #(
    parameter int READ_TRIES = 5
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        busy,
    input logic        done,
    input logic        err,
    input logic        is_read,
    input logic [7:0]  cmd_key,
    input logic        cmd_addr_we,
    input logic        cmd_data_we,
    input logic [15:0] rd_data
);
    localparam int CW = $clog2(READ_TRIES + 1) + 1;

    logic [CW-1:0] strobes_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          strobes_q <= '0;
        else if (done)       strobes_q <= '0;
        else if (cmd_addr_we) strobes_q <= strobes_q + 1'b1;
    end

    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!cmd_addr_we && !cmd_data_we)); // R1

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_addr_we, cmd_data_we})); // R3

    AST_DATA_THEN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_addr_we && !is_read) |-> $past(cmd_data_we)); // R3

    AST_TRY_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_addr_we |-> (is_read ? (strobes_q < CW'(READ_TRIES)) : (strobes_q == '0))); // R10

    AST_FAIL_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err && is_read) |-> (rd_data == 16'hFFFF)); // R10

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy)); // R11

    AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy); // R11

    AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid) |=> $stable(cmd_key)); // R12
endmodule

bind codec_reg_engine codec_reg_engine_chk #(.READ_TRIES(READ_TRIES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .busy        (busy),
    .done        (done),
    .err         (err),
    .is_read     (cmd_addr_word[19]),
    .cmd_key     (cmd_addr_word[19:12]),
    .cmd_addr_we (cmd_addr_we),
    .cmd_data_we (cmd_data_we),
    .rd_data     (rd_data)
);

// File: tb/tb_codec_reg_engine.sv
`timescale 1ns/1ps
module tb_codec_reg_engine;
    localparam int DIV      = 4;
    localparam int WR_US    = 500;
    localparam int AS_US    = 21;
    localparam int RDY_US   = 500;
    localparam int GAP_US   = 21;
    localparam int TRIES    = 5;
    localparam int RSP_DLY  = 10;
    localparam int WDOG     = 150000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0, req_write = 1'b0;
    logic [6:0]   req_index = '0;
    logic [15:0]  req_wdata = '0;
    logic         busy, done, err, cmd_addr_we, cmd_data_we;
    logic [15:0]  rd_data;
    logic [31:0]  cmd_addr_word, cmd_data_word;
    logic [31:30] tx_status = '0, tx_clr;
    logic [22:21] rx_status = '0, rx_clr;
    logic [18:12] rsp_addr_word = '0;
    logic [19:4]  rsp_data_word = '0;

    codec_reg_engine #(
        .CLK_PER_US(DIV), .WR_TMO_US(WR_US), .ASENT_TMO_US(AS_US),
        .READY_TMO_US(RDY_US), .RETRY_GAP_US(GAP_US), .READ_TRIES(TRIES)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_index(req_index), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rd_data(rd_data), .err(err), .cmd_addr_word(cmd_addr_word),
        .cmd_addr_we(cmd_addr_we), .cmd_data_word(cmd_data_word),
        .cmd_data_we(cmd_data_we), .tx_status(tx_status), .tx_clr(tx_clr),
        .rx_status(rx_status), .rx_clr(rx_clr), .rsp_addr_word(rsp_addr_word),
        .rsp_data_word(rsp_data_word)
    );

    always #2 clk = ~clk;

    int  cyc = 0;
    int  errors = 0, checks = 0;
    bit  hung = 1'b0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WDOG) hung <= 1'b1;
    end

    // Responder model settings
    bit          m_ack, m_rx, m_aready, m_dready;
    int          m_bad;
    logic [15:0] m_data;
    // Responder observations
    int n_addr, n_data, n_done, clr_both_cyc, data_cyc, addr_cyc, last_addr, min_gap, pend;
    bit          pend_rd;
    logic [6:0]  pend_idx;

    always @(negedge clk) begin
        logic [31:30] tn;
        logic [22:21] rn;
        tn = tx_status & ~tx_clr;
        rn = rx_status & ~rx_clr;
        if (rst_n) begin
            if (tx_clr == 2'b11 && clr_both_cyc < 0) clr_both_cyc = cyc;
            if (done) n_done++;
            if (cmd_data_we) begin n_data++; data_cyc = cyc; end
            if (cmd_addr_we) begin
                n_addr++;
                if (last_addr >= 0 && (cyc - last_addr) < min_gap) min_gap = cyc - last_addr;
                last_addr = cyc;
                addr_cyc  = cyc;
                pend      = RSP_DLY;
                pend_rd   = cmd_addr_word[19];
                pend_idx  = cmd_addr_word[18:12];
            end else if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    if (m_ack) begin
                        tn[31] = 1'b1;
                        if (!pend_rd) tn[30] = 1'b1;
                    end
                    if (pend_rd && m_rx) begin
                        rsp_addr_word = (n_addr <= m_bad) ? (pend_idx ^ 7'h01) : pend_idx;
                        rsp_data_word = m_data;
                        if (m_aready) rn[22] = 1'b1;
                        if (m_dready) rn[21] = 1'b1;
                    end
                end
            end
        end
        tx_status = tn;
        rx_status = rn;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic setup(input bit ack, input bit rx, input bit ar, input bit dr,
                         input int bad, input logic [15:0] d);
        m_ack = ack; m_rx = rx; m_aready = ar; m_dready = dr; m_bad = bad; m_data = d;
        n_addr = 0; n_data = 0; n_done = 0; clr_both_cyc = -1; data_cyc = -1;
        addr_cyc = -1; last_addr = -1; min_gap = 1 << 30; pend = 0;
    endtask

    logic [15:0] r_data;
    bit          r_err;
    int          r_time;

    task automatic wait_done();
        while (!done && !hung) @(negedge clk);
        r_data = rd_data;
        r_err  = err;
        @(negedge clk);
        chk(!done, "R11", "done lasts one cycle", done, 0);
        chk(!busy, "R11", "busy falls after done", busy, 0);
    endtask

    task automatic run_req(input bit wr, input logic [6:0] idx, input logic [15:0] wd);
        int start;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_index = idx; req_wdata = wd;
        start = cyc;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy, "R11", "busy after accept", busy, 1);
        while (!done && !hung) @(negedge clk);
        r_time = cyc - start;
        wait_done_tail();
    endtask

    task automatic wait_done_tail();
        r_data = rd_data;
        r_err  = err;
        @(negedge clk);
        chk(!done, "R11", "done lasts one cycle", done, 0);
        chk(!busy, "R11", "busy falls after done", busy, 0);
    endtask

    task automatic t_reset();
        chk(!busy && !done && !err, "R1", "flags after reset", {busy, done, err}, 0);
        chk(rd_data == 16'h0, "R1", "rd_data after reset", rd_data, 0);
    endtask

    task automatic t_write_ok();
        setup(1, 0, 0, 0, 0, 16'h0);
        run_req(1'b1, 7'h2C, 16'hA5C3);
        chk(!r_err, "R4", "write err", r_err, 0);
        chk(n_addr == 1 && n_data == 1, "R4", "write strobes", n_addr, 1);
        chk(cmd_addr_word == {12'h0, 1'b0, 7'h2C, 12'h0}, "R2", "write addr word",
            cmd_addr_word, {12'h0, 1'b0, 7'h2C, 12'h0});
        chk(cmd_data_word == {12'h0, 16'hA5C3, 4'h0}, "R2", "write data word",
            cmd_data_word, {12'h0, 16'hA5C3, 4'h0});
        chk(clr_both_cyc >= 0 && clr_both_cyc < data_cyc, "R3", "clear before data",
            clr_both_cyc, data_cyc - 1);
        chk(addr_cyc == data_cyc + 1, "R3", "addr right after data", addr_cyc, data_cyc + 1);
        chk(tx_status == 2'b00, "R4", "sent flags cleared", tx_status, 0);
    endtask

    task automatic t_write_timeout();
        setup(0, 0, 0, 0, 0, 16'h0);
        run_req(1'b1, 7'h05, 16'h1234);
        chk(r_err, "R4", "write timeout err", r_err, 1);
        chk(n_addr == 1, "R4", "write not retried", n_addr, 1);
        chk(r_time >= WR_US * DIV && r_time < WR_US * DIV + 40, "R13", "write timeout length",
            r_time, WR_US * DIV);
    endtask

    task automatic t_read_ok();
        setup(1, 1, 1, 1, 0, 16'h5A0F);
        run_req(1'b0, 7'h1A, 16'h0);
        chk(!r_err && r_data == 16'h5A0F, "R8", "read data", r_data, 16'h5A0F);
        chk(n_addr == 1 && n_data == 0, "R5", "single read issue", n_addr, 1);
        chk(cmd_addr_word == {12'h0, 1'b1, 7'h1A, 12'h0}, "R2", "read addr word",
            cmd_addr_word, {12'h0, 1'b1, 7'h1A, 12'h0});
        chk(tx_status == 2'b00, "R5", "addr-sent cleared", tx_status, 0);
        chk(rx_status == 2'b00, "R8", "ready flags cleared", rx_status, 0);
    endtask

    task automatic t_read_noack();
        setup(0, 1, 1, 1, 0, 16'h0C0D);
        run_req(1'b0, 7'h33, 16'h0);
        chk(!r_err && r_data == 16'h0C0D, "R5", "read without addr-sent", r_data, 16'h0C0D);
        chk(r_time >= AS_US * DIV, "R5", "addr-sent wait length", r_time, AS_US * DIV);
    endtask

    task automatic t_read_dataonly();
        setup(1, 1, 0, 1, 0, 16'h7E11);
        run_req(1'b0, 7'h40, 16'h0);
        chk(!r_err && r_data == 16'h7E11, "R6", "data-ready only", r_data, 16'h7E11);
        chk(n_addr == 1, "R6", "no retry on one timeout", n_addr, 1);
        chk(r_time >= RDY_US * DIV, "R6", "address-ready wait length", r_time, RDY_US * DIV);
    endtask

    task automatic t_read_retry();
        setup(1, 1, 1, 1, 2, 16'hBEEF);
        run_req(1'b0, 7'h26, 16'h0);
        chk(!r_err && r_data == 16'hBEEF, "R9", "read after mismatches", r_data, 16'hBEEF);
        chk(n_addr == 3, "R9", "attempts after two mismatches", n_addr, 3);
        chk(min_gap >= GAP_US * DIV, "R9", "retry gap", min_gap, GAP_US * DIV);
    endtask

    task automatic t_read_allbad();
        setup(1, 1, 1, 1, 99, 16'h1111);
        run_req(1'b0, 7'h0E, 16'h0);
        chk(n_addr == TRIES, "R10", "attempt count", n_addr, TRIES);
        chk(r_err && r_data == 16'hFFFF, "R10", "failure value", r_data, 16'hFFFF);
    endtask

    task automatic t_read_linkdown();
        setup(1, 0, 0, 0, 0, 16'h0);
        run_req(1'b0, 7'h7C, 16'h0);
        chk(n_addr == TRIES, "R7", "attempts when link down", n_addr, TRIES);
        chk(r_err && r_data == 16'hFFFF, "R10", "link down value", r_data, 16'hFFFF);
        chk(min_gap >= 2 * RDY_US * DIV && min_gap < 2 * RDY_US * DIV + GAP_US * DIV,
            "R7", "no gap after link down", min_gap, 2 * RDY_US * DIV);
    endtask

    task automatic t_busy_ignore();
        setup(1, 0, 0, 0, 0, 16'h0);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_index = 7'h11; req_wdata = 16'h2222;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_index = 7'h6A;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done && !hung) @(negedge clk);
        wait_done_tail();
        repeat (60) @(negedge clk);
        chk(n_done == 1 && n_addr == 1, "R12", "extra request ignored", n_done, 1);
        chk(cmd_addr_word[19:12] == {1'b0, 7'h11}, "R12", "latched command kept",
            cmd_addr_word[19:12], {1'b0, 7'h11});
    endtask

    initial begin
        setup(0, 0, 0, 0, 0, 16'h0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_ok();
        t_write_timeout();
        t_read_ok();
        t_read_noack();
        t_read_dataonly();
        t_read_retry();
        t_read_allbad();
        t_read_linkdown();
        t_busy_ignore();
        if (hung) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule